// File: doc/BRIEF.md
# Video Processor Host Port Controller

This block is the host-facing front end of a video processor. A 16-bit host issues writes on two ports, a control port and a data port, and reads a status word from the control port. Commands arrive as two consecutive control words. Together they build a 16-bit target address and a 6-bit access code. A flag records that the first half of a command has been taken.

Data-port writes are queued, together with the current address and code, in a small write queue. A downstream memory writer drains that queue. After each queued write, the address steps forward by a programmable increment. While an external transfer engine reports that it is busy, the block refuses every host write and leaves its state untouched. The transfer-type field of the engine's source register is passed through to that engine.

Top module: `vid_host_port`

## Requirements
- R1: While `dma_busy` is high, any control or data write raises `wr_reject` in the same cycle and changes neither the address, the code, the half-command flag nor the queue.
- R2: A control write taken while the half-command flag is clear loads address bits 13:0 from word bits 13:0 and code bits 1:0 from word bits 15:14. It keeps address bits 15:14 and code bits 5:2, and it sets the flag.
- R3: A control write taken while the flag is set loads address bits 15:14 from word bits 1:0 and code bits 5:2 from word bits 7:4. It keeps address bits 13:0 and code bits 1:0, and it clears the flag.
- R4: A data write while code bit 0 is 0 (read access) is dropped. Nothing is queued, the address is kept and the flag is kept.
- R5: A data write accepted while code bit 0 is 1 queues one entry holding the current address, code and data, and clears the flag.
- R6: After each accepted data write, the address advances by `addr_step`, modulo 2^16.
- R7: A write-mode data write that finds the queue full raises `wr_wait` in the same cycle and queues nothing. It is accepted on the first clock edge after space frees.
- R8: One cycle after a `stat_rd` pulse, `stat_word` holds bit 9 = queue empty, bit 8 = queue full and bit 1 = `dma_busy`, with all other bits 0. Bit 1 depends on no mode setting.
- R9: A control read clears the half-command flag.
- R10: `xfer_kind` equals bits 7:6 of `dma_src_hi`, delayed by one register.
- R11: The queue holds 4 entries and presents them at `q_addr`/`q_code`/`q_data` in arrival order. `q_valid` is high while it is non-empty, and `q_pop` removes the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control-port write strobe |
| data_wr | input | 1 | Data-port write strobe |
| wr_word | input | 16 | Write value for either port |
| stat_rd | input | 1 | Control-port read strobe |
| stat_word | output | 16 | Registered status word |
| wr_reject | output | 1 | Write refused because a transfer is running |
| wr_wait | output | 1 | Data write stalled on a full queue |
| dma_busy | input | 1 | Transfer engine running |
| addr_step | input | 8 | Address increment per data write |
| dma_src_hi | input | 8 | Transfer source high register |
| xfer_kind | output | 2 | Transfer type field to the engine |
| q_pop | input | 1 | Remove queue head |
| q_valid | output | 1 | Queue non-empty |
| q_addr | output | 16 | Head entry address |
| q_code | output | 6 | Head entry access code |
| q_data | output | 16 | Head entry data |

## Verification
The assertions take it that at most one of `ctl_wr`, `data_wr` and `stat_rd` is high in a cycle. They also take it that a host seeing `wr_wait` holds its data write until the wait drops. The bench drives one strobe per task and keeps a stalled write asserted across the pop that frees space. Queue-level checks allow for a same-cycle pop, and the directed tasks pop only while no write is pending.

// File: rtl/vid_host_pkg.sv
package vid_host_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int CODE_W = 6;
  localparam int LOW_W  = 14;            // address bits loaded by the first word
  localparam int CLO_W  = 2;             // code bits loaded by the first word
  localparam int STAT_W = 16;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [CODE_W-1:0] code;
    logic [DATA_W-1:0] data;
  } wq_entry_t;

  localparam int ENTRY_W = $bits(wq_entry_t);
endpackage

// File: rtl/vid_cmd_reg.sv
module vid_cmd_reg
  import vid_host_pkg::*;
#(
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_take,
  input  logic [DATA_W-1:0] word,
  input  logic              data_take,
  input  logic              rd_clear,
  input  logic [STEP_W-1:0] step,
  output logic [ADDR_W-1:0] addr,
  output logic [CODE_W-1:0] code,
  output logic              half_cmd
);
  localparam int HI_W = ADDR_W - LOW_W;
  localparam int CHI_W = CODE_W - CLO_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr     <= '0;
      code     <= '0;
      half_cmd <= 1'b0;
    end else if (ctl_take) begin
      if (half_cmd) begin
        addr[ADDR_W-1:LOW_W] <= word[HI_W-1:0];
        code[CODE_W-1:CLO_W] <= word[4 +: CHI_W];
        half_cmd             <= 1'b0;
      end else begin
        addr[LOW_W-1:0] <= word[LOW_W-1:0];
        code[CLO_W-1:0] <= word[DATA_W-1 -: CLO_W];
        half_cmd        <= 1'b1;
      end
    end else if (data_take) begin
      addr     <= addr + ADDR_W'(step);
      half_cmd <= 1'b0;
    end else if (rd_clear) begin
      half_cmd <= 1'b0;
    end
  end
endmodule

// File: rtl/vid_wr_queue.sv
module vid_wr_queue #(
  parameter int WIDTH = 38,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp, rp;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign full  = (level == CW'(DEPTH));
  assign empty = (level == '0);
endmodule

// File: rtl/vid_status_reg.sv
module vid_status_reg
  import vid_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              q_full,
  input  logic              q_empty,
  input  logic              busy,
  output logic [STAT_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
    end else if (rd) begin
      word    <= '0;
      word[9] <= q_empty;
      word[8] <= q_full;
      word[1] <= busy;
    end
  end
endmodule

// File: rtl/vid_host_port.sv
module vid_host_port
  import vid_host_pkg::*;
#(
  parameter int Q_DEPTH = 4,
  parameter int STEP_W  = 8,
  parameter int SRC_W   = 8,
  localparam int LVL_W  = $clog2(Q_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              stat_rd,
  output logic [STAT_W-1:0] stat_word,
  output logic              wr_reject,
  output logic              wr_wait,
  input  logic              dma_busy,
  input  logic [STEP_W-1:0] addr_step,
  input  logic [SRC_W-1:0]  dma_src_hi,
  output logic [1:0]        xfer_kind,
  input  logic              q_pop,
  output logic              q_valid,
  output logic [ADDR_W-1:0] q_addr,
  output logic [CODE_W-1:0] q_code,
  output logic [DATA_W-1:0] q_data
);
  logic [ADDR_W-1:0] cmd_addr;
  logic [CODE_W-1:0] cmd_code;
  logic              half_cmd;
  logic              ctl_take, data_try, data_take, pop_take;
  logic              q_full, q_empty;
  logic [LVL_W-1:0]  q_level;
  wq_entry_t         in_ent, head_ent;

  assign ctl_take  = ctl_wr & ~dma_busy;
  assign data_try  = data_wr & ~dma_busy & cmd_code[0];
  assign data_take = data_try & ~q_full;
  assign wr_wait   = data_try & q_full;
  assign wr_reject = (ctl_wr | data_wr) & dma_busy;
  assign pop_take  = q_pop & ~q_empty;

  vid_cmd_reg #(.STEP_W(STEP_W)) u_cmd (
    .clk(clk), .rst(rst), .ctl_take(ctl_take), .word(wr_word),
    .data_take(data_take), .rd_clear(stat_rd), .step(addr_step),
    .addr(cmd_addr), .code(cmd_code), .half_cmd(half_cmd)
  );

  assign in_ent = '{addr: cmd_addr, code: cmd_code, data: wr_word};

  vid_wr_queue #(.WIDTH(ENTRY_W), .DEPTH(Q_DEPTH)) u_q (
    .clk(clk), .rst(rst), .push(data_take), .din(in_ent), .pop(pop_take),
    .dout(head_ent), .full(q_full), .empty(q_empty), .level(q_level)
  );

  vid_status_reg u_stat (
    .clk(clk), .rst(rst), .rd(stat_rd), .q_full(q_full),
    .q_empty(q_empty), .busy(dma_busy), .word(stat_word)
  );

  always_ff @(posedge clk) begin
    if (rst) xfer_kind <= '0;
    else     xfer_kind <= dma_src_hi[SRC_W-1 -: 2];
  end

  assign q_valid = ~q_empty;
  assign q_addr  = head_ent.addr;
  assign q_code  = head_ent.code;
  assign q_data  = head_ent.data;
endmodule

// File: rtl/vid_host_port_chk.sv
module vid_host_port_chk #(
  parameter int DEPTH = 4,
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             ctl_wr,
  input logic             data_wr,
  input logic             stat_rd,
  input logic             dma_busy,
  input logic             wr_reject,
  input logic             wr_wait,
  input logic             q_pop,
  input logic [15:0]      stat_word,
  input logic [LVL_W-1:0] q_level,
  input logic             code0
);
  a_r1_reject: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr || data_wr) && dma_busy |-> wr_reject);
  a_r1_queue_held: assert property (@(posedge clk) disable iff (rst)
    dma_busy && !q_pop |=> q_level == $past(q_level));
  a_r4_ignored: assert property (@(posedge clk) disable iff (rst)
    data_wr && !dma_busy && !code0 && !q_pop |=> q_level == $past(q_level));
  a_r5_push: assert property (@(posedge clk) disable iff (rst)
    data_wr && !dma_busy && code0 && (q_level < LVL_W'(DEPTH)) && !q_pop
    |=> q_level == $past(q_level) + 1'b1);
  a_r7_wait_no_push: assert property (@(posedge clk) disable iff (rst)
    wr_wait && !q_pop |=> q_level == $past(q_level));
  a_r8_status_busy: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> stat_word[1] == $past(dma_busy));
  a_r8_status_full: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> stat_word[8] == $past(q_level == LVL_W'(DEPTH)));

  always_ff @(posedge clk) begin
    if (!rst) a_r11_bound: assert (q_level <= LVL_W'(DEPTH));
  end
endmodule

bind vid_host_port vid_host_port_chk #(.DEPTH(Q_DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .data_wr(data_wr), .stat_rd(stat_rd),
  .dma_busy(dma_busy), .wr_reject(wr_reject), .wr_wait(wr_wait), .q_pop(q_pop),
  .stat_word(stat_word), .q_level(q_level), .code0(cmd_code[0])
);

// File: tb/vid_host_port_bench.sv
module vid_host_port_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_wr = 0, data_wr = 0, stat_rd = 0, dma_busy = 0, q_pop = 0;
  logic [15:0] wr_word = '0;
  logic [7:0] addr_step = 8'd1, dma_src_hi = '0;
  logic [15:0] stat_word, q_addr, q_data;
  logic [5:0] q_code;
  logic [1:0] xfer_kind;
  logic wr_reject, wr_wait, q_valid;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vid_host_port u_vid_host_port (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .data_wr(data_wr), .wr_word(wr_word),
    .stat_rd(stat_rd), .stat_word(stat_word), .wr_reject(wr_reject),
    .wr_wait(wr_wait), .dma_busy(dma_busy), .addr_step(addr_step),
    .dma_src_hi(dma_src_hi), .xfer_kind(xfer_kind), .q_pop(q_pop),
    .q_valid(q_valid), .q_addr(q_addr), .q_code(q_code), .q_data(q_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [15:0] v);
    @(negedge clk); ctl_wr = 1; wr_word = v;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic data_write(input logic [15:0] v);
    @(negedge clk); data_wr = 1; wr_word = v;
    @(negedge clk); data_wr = 0;
  endtask

  task automatic read_status(input string req, input logic [15:0] exp);
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
    check(req, stat_word, exp);
  endtask

  task automatic pop_expect(input string req, input logic [15:0] a,
                            input logic [5:0] c, input logic [15:0] d);
    @(negedge clk);
    check(req, {q_valid, q_addr, q_code}, {1'b1, a, c});
    check(req, q_data, d);
    q_pop = 1;
    @(negedge clk); q_pop = 0;
  endtask

  task automatic t_reset;
    check("R11 reset empty", q_valid, 0);
    read_status("R8 reset status", 16'h0200);
  endtask

  task automatic t_kind;
    dma_src_hi = 8'hC5;
    @(negedge clk);
    check("R10 kind", xfer_kind, 2'b11);
    dma_src_hi = 8'h40;
    @(negedge clk);
    check("R10 kind", xfer_kind, 2'b01);
  endtask

  task automatic t_read_clears;
    addr_step = 8'd1;
    ctl_write(16'h4100);
    read_status("R9 status", 16'h0200);
    ctl_write(16'h4200);           // first word again if flag was cleared
    data_write(16'h1234);
    pop_expect("R9 read clears flag", 16'h0200, 6'h01, 16'h1234);
  endtask

  task automatic t_data_clears;
    ctl_write(16'h4300);
    data_write(16'h5555);
    ctl_write(16'h4400);
    data_write(16'h6666);
    pop_expect("R5 entry", 16'h0300, 6'h01, 16'h5555);
    pop_expect("R5 write clears flag", 16'h0400, 6'h01, 16'h6666);
  endtask

  task automatic t_cmd_pair;
    addr_step = 8'd2;
    ctl_write(16'h4123);
    ctl_write(16'h0012);
    data_write(16'hBEEF);
    data_write(16'hCAFE);
    pop_expect("R3 second word", 16'h8123, 6'h05, 16'hBEEF);
    pop_expect("R6 step", 16'h8125, 6'h05, 16'hCAFE);
    addr_step = 8'hFF;
    ctl_write(16'h7FFF);           // addr 3FFF | C000, code 01
    ctl_write(16'h0003);
    data_write(16'h0001);
    data_write(16'h0002);
    pop_expect("R2 first word", 16'hFFFF, 6'h01, 16'h0001);
    pop_expect("R6 wrap", 16'h00FE, 6'h01, 16'h0002);
  endtask

  task automatic t_read_mode;
    addr_step = 8'd1;
    ctl_write(16'h8040);
    ctl_write(16'h0000);
    data_write(16'hAAAA);
    @(negedge clk);
    check("R4 no push", q_valid, 0);
    ctl_write(16'h4050);
    ctl_write(16'h0000);
    data_write(16'h7777);
    pop_expect("R4 later write", 16'h0050, 6'h01, 16'h7777);
  endtask

  task automatic t_busy;
    ctl_write(16'h4010);
    ctl_write(16'h0000);
    @(negedge clk); dma_busy = 1; ctl_wr = 1; wr_word = 16'h4999;
    #1 check("R1 reject ctl", wr_reject, 1);
    @(negedge clk); ctl_wr = 0; data_wr = 1; wr_word = 16'h1111;
    #1 check("R1 reject data", wr_reject, 1);
    @(negedge clk); data_wr = 0;
    check("R1 no push", q_valid, 0);
    read_status("R8 busy bit", 16'h0202);
    @(negedge clk); dma_busy = 0;
    data_write(16'h2222);
    pop_expect("R1 state kept", 16'h0010, 6'h01, 16'h2222);
  endtask

  task automatic t_full;
    addr_step = 8'd1;
    ctl_write(16'h4000);
    ctl_write(16'h0000);
    for (int i = 0; i < 4; i++) data_write(16'hD000 + 16'(i));
    read_status("R8 full bit", 16'h0100);
    @(negedge clk); data_wr = 1; wr_word = 16'hD004;
    #1 check("R7 wait", wr_wait, 1);
    @(negedge clk);
    check("R7 held", wr_wait, 1);
    check("R7 no push", q_data, 16'hD000);
    q_pop = 1;
    @(negedge clk); q_pop = 0;
    check("R7 released", wr_wait, 0);
    @(negedge clk); data_wr = 0;
    for (int i = 1; i < 5; i++)
      pop_expect("R11 order", 16'(i), 6'h01, 16'hD000 + 16'(i));
    @(negedge clk);
    check("R11 drained", q_valid, 0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_kind();
    t_read_clears();
    t_data_clears();
    t_cmd_pair();
    t_read_mode();
    t_busy();
    t_full();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end
endmodule